// File: doc/BRIEF.md
# Serial Destination Address Filter

This block decides whether a received Ethernet frame is wanted by this station. The 48 bits of the destination address enter one per clock on a qualified serial input, right after a frame-start strobe. While the bits shift in, the block assembles the address and runs a CRC-32 over it. On the cycle after the last address bit, it gives one registered accept or reject verdict. The receive path can then keep or drop the frame before any payload is stored.

Four checks feed the verdict:
- An individual address must match the station address exactly.
- A group address is accepted when it equals the programmable broadcast pattern.
- Any other group address goes through a 64-bit hash mask. The mask only removes most unwanted multicasts, so accepted ones may still need a later exact check.
- A promiscuous switch accepts everything.

The host programs the station address, the broadcast pattern, the mask and the switch through a 16-bit write port.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset, `dec_vld` and `dec_accept` are low, the station address and hash mask are all zeros, promiscuous mode is off, and the broadcast pattern is all ones.
- R2: Address bit i (i = 0..47) is the i-th bit taken with `bit_vld` high after a frame start, so the first bit is address bit 0. `dec_vld` is high for exactly one cycle, the cycle after the 48th bit is taken, and is low during the address.
- R3: When address bit 0 is 0 (individual address), the frame is accepted only if all 48 bits equal the station address.
- R4: When address bit 0 is 1 and the address equals the broadcast pattern, the frame is accepted whatever the hash mask holds.
- R5: Any other address with bit 0 set is accepted only if mask bit h is 1. Here h is bits 31..26 of a CRC-32 with polynomial 0x04C11DB7. The register is preset to all ones and shifted left once per address bit in arrival order, with feedback = register bit 31 XOR the incoming bit. No final inversion or bit reversal is applied.
- R6: With promiscuous mode on, every completed address is accepted.
- R7: `frm_start` restarts address collection. A frame cut short by a new strobe gives no verdict. A `bit_vld` in the same cycle as `frm_start` is not taken as an address bit.
- R8: Bits presented with no frame open (before the first strobe, or after the 48th bit until the next strobe) are ignored and produce no verdict.
- R9: A write with `cfg_we` high stores `cfg_wdata` into the word chosen by `cfg_sel`, as follows:
  - codes 0, 1, 2: station address bits [15:0], [31:16], [47:32]
  - codes 4, 5, 6: broadcast pattern bits [15:0], [31:16], [47:32]
  - codes 8 to 11: mask bits [15:0] up to [63:48]
  - code 12: data bit 0 is the promiscuous switch
- R10: `dec_accept` is low in every cycle where `dec_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_start | input | 1 | Frame-start strobe; opens a new address |
| bit_vld | input | 1 | Qualifies `bit_in` this cycle |
| bit_in | input | 1 | Serial destination address bit |
| cfg_we | input | 1 | Host write enable |
| cfg_sel | input | 4 | Host word selector |
| cfg_wdata | input | 16 | Host write data |
| dec_vld | output | 1 | Verdict valid, one cycle |
| dec_accept | output | 1 | Frame accepted (meaningful with `dec_vld`) |

## Verification
The hardest case to reach from the ports is a multicast whose hash lands on a set mask bit while its address differs from every programmed one. Such an address only passes if the mask index was computed correctly. The bench derives the index of chosen wanted group addresses itself, programs only those mask bits, and then sends both those addresses and unrelated group addresses. Any error in the CRC order, preset or polynomial therefore shows up as a wrong verdict. Aborted frames, a strobe that coincides with a valid bit, and bits streamed past the 48th are driven directly, and the number of verdict pulses is counted.

// File: rtl/daf_pkg.sv
package daf_pkg;
  localparam int DAF_ADDR_W = 48;
  localparam int DAF_HASH_W = 6;
  localparam int DAF_DW     = 16;
  localparam int DAF_SEL_W  = 4;
  localparam int CRC_W      = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_INIT = '1;

  // host word selector bases
  localparam logic [DAF_SEL_W-1:0] SEL_STA  = 4'd0;
  localparam logic [DAF_SEL_W-1:0] SEL_BC   = 4'd4;
  localparam logic [DAF_SEL_W-1:0] SEL_MASK = 4'd8;
  localparam logic [DAF_SEL_W-1:0] SEL_CTRL = 4'd12;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/daf_regs.sv
module daf_regs
  import daf_pkg::*;
#(
  parameter int ADDR_W = DAF_ADDR_W,
  parameter int MASK_W = 64,
  parameter int DW     = DAF_DW,
  parameter int SEL_W  = DAF_SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [ADDR_W-1:0] sta_addr,
  output logic [ADDR_W-1:0] bc_addr,
  output logic [MASK_W-1:0] hash_mask,
  output logic              promisc
);
  localparam int AWORDS = (ADDR_W + DW - 1) / DW;
  localparam int MWORDS = (MASK_W + DW - 1) / DW;
  localparam int AW_PAD = AWORDS * DW;
  localparam int MW_PAD = MWORDS * DW;

  logic [AW_PAD-1:0] sta_q, sta_nx, bc_q, bc_nx;
  logic [MW_PAD-1:0] msk_q, msk_nx;
  logic              prm_q, prm_nx;
  logic              unused_wdata;

  assign unused_wdata = ^cfg_wdata[DW-1:1];

  always_comb begin
    sta_nx = sta_q;
    bc_nx  = bc_q;
    msk_nx = msk_q;
    prm_nx = prm_q;
    for (int w = 0; w < AWORDS; w++) begin
      if (cfg_sel == SEL_STA + SEL_W'(w)) sta_nx[w*DW +: DW] = cfg_wdata;
      if (cfg_sel == SEL_BC + SEL_W'(w))  bc_nx[w*DW +: DW]  = cfg_wdata;
    end
    for (int w = 0; w < MWORDS; w++) begin
      if (cfg_sel == SEL_MASK + SEL_W'(w)) msk_nx[w*DW +: DW] = cfg_wdata;
    end
    if (cfg_sel == SEL_CTRL) prm_nx = cfg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta_q <= '0;
      bc_q  <= '1;
      msk_q <= '0;
      prm_q <= 1'b0;
    end else if (cfg_we) begin
      sta_q <= sta_nx;
      bc_q  <= bc_nx;
      msk_q <= msk_nx;
      prm_q <= prm_nx;
    end
  end

  assign sta_addr  = sta_q[ADDR_W-1:0];
  assign bc_addr   = bc_q[ADDR_W-1:0];
  assign hash_mask = msk_q[MASK_W-1:0];
  assign promisc   = prm_q;

  // R9: a control write lands in the promiscuous switch
  a_r9_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_CTRL) |=> (promisc == $past(cfg_wdata[0])));
  // R9: writes to other words leave the switch alone
  a_r9_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_sel == SEL_CTRL) |=> $stable(promisc));
endmodule

// File: rtl/daf_collect.sv
module daf_collect
  import daf_pkg::*;
#(
  parameter int ADDR_W = DAF_ADDR_W,
  parameter int HASH_W = DAF_HASH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_start,
  input  logic              bit_vld,
  input  logic              bit_in,
  output logic              last_bit,
  output logic [ADDR_W-1:0] addr_full,
  output logic [HASH_W-1:0] hash_idx
);
  localparam int CNT_W = $clog2(ADDR_W + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ADDR_W - 1);

  logic              active_q, active_nx;
  logic [CNT_W-1:0]  cnt_q, cnt_nx;
  logic [ADDR_W-1:0] sh_q, sh_nx, sh_step;
  logic [CRC_W-1:0]  crc_q, crc_nx, crc_next_bit;
  logic              take, upd;

  assign take         = active_q & bit_vld & ~frm_start;
  assign upd          = frm_start | take;
  assign sh_step      = {bit_in, sh_q[ADDR_W-1:1]};
  assign crc_next_bit = crc_step(crc_q, bit_in);
  assign last_bit     = take && (cnt_q == LAST_CNT);
  assign addr_full    = sh_step;
  assign hash_idx     = crc_next_bit[CRC_W-1 -: HASH_W];

  always_comb begin
    active_nx = active_q;
    cnt_nx    = cnt_q;
    sh_nx     = sh_q;
    crc_nx    = crc_q;
    if (frm_start) begin
      active_nx = 1'b1;
      cnt_nx    = '0;
      sh_nx     = '0;
      crc_nx    = CRC_INIT;
    end else if (take) begin
      sh_nx     = sh_step;
      crc_nx    = crc_next_bit;
      cnt_nx    = cnt_q + 1'b1;
      active_nx = (cnt_q != LAST_CNT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      crc_q    <= CRC_INIT;
    end else if (upd) begin
      active_q <= active_nx;
      cnt_q    <= cnt_nx;
      sh_q     <= sh_nx;
      crc_q    <= crc_nx;
    end
  end

  // R2: the bit counter stays inside the address while collecting
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q < CNT_W'(ADDR_W)));
  // R7: a strobe reopens collection from bit zero
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |=> (active_q && cnt_q == '0));
  // R8: with no frame open the collector state does not move
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !frm_start) |=> ($stable(cnt_q) && !active_q));
endmodule

// File: rtl/daf_decide.sv
module daf_decide
  import daf_pkg::*;
#(
  parameter int ADDR_W = DAF_ADDR_W,
  parameter int HASH_W = DAF_HASH_W,
  parameter int MASK_W = 1 << HASH_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [HASH_W-1:0] hash_idx,
  input  logic [ADDR_W-1:0] sta_addr,
  input  logic [ADDR_W-1:0] bc_addr,
  input  logic [MASK_W-1:0] hash_mask,
  input  logic              promisc,
  output logic              accept
);
  logic is_group, sta_hit, bc_hit, hash_hit;

  always_comb begin
    is_group = addr[0];
    sta_hit  = (addr == sta_addr);
    bc_hit   = (addr == bc_addr);
    hash_hit = hash_mask[hash_idx];
    if (promisc)       accept = 1'b1;
    else if (is_group) accept = bc_hit | hash_hit;
    else               accept = sta_hit;
  end
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import daf_pkg::*;
#(
  parameter int ADDR_W = DAF_ADDR_W,
  parameter int HASH_W = DAF_HASH_W,
  parameter int DW     = DAF_DW,
  parameter int SEL_W  = DAF_SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_start,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [DW-1:0]    cfg_wdata,
  output logic             dec_vld,
  output logic             dec_accept
);
  localparam int MASK_W = 1 << HASH_W;

  logic [ADDR_W-1:0] sta_addr, bc_addr, addr_full;
  logic [MASK_W-1:0] hash_mask;
  logic [HASH_W-1:0] hash_idx;
  logic              promisc, last_bit, accept;
  logic              vld_q, vld_nx, acc_q, acc_nx;

  daf_regs #(.ADDR_W(ADDR_W), .MASK_W(MASK_W), .DW(DW), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .sta_addr(sta_addr), .bc_addr(bc_addr),
    .hash_mask(hash_mask), .promisc(promisc)
  );

  daf_collect #(.ADDR_W(ADDR_W), .HASH_W(HASH_W)) u_collect (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .bit_vld(bit_vld),
    .bit_in(bit_in), .last_bit(last_bit), .addr_full(addr_full),
    .hash_idx(hash_idx)
  );

  daf_decide #(.ADDR_W(ADDR_W), .HASH_W(HASH_W), .MASK_W(MASK_W)) u_decide (
    .addr(addr_full), .hash_idx(hash_idx), .sta_addr(sta_addr),
    .bc_addr(bc_addr), .hash_mask(hash_mask), .promisc(promisc),
    .accept(accept)
  );

  always_comb begin
    vld_nx = last_bit;
    acc_nx = last_bit & accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      acc_q <= 1'b0;
    end else begin
      vld_q <= vld_nx;
      acc_q <= acc_nx;
    end
  end

  assign dec_vld    = vld_q;
  assign dec_accept = acc_q;

  // R2: a verdict lasts a single cycle
  a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |=> !dec_vld);
  // R2/R7: a verdict follows a bit taken outside a strobe cycle
  a_r2_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |-> $past(bit_vld && !frm_start));
  // R10: accept only qualifies a valid verdict
  a_r10_acc_qual: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_vld |-> !dec_accept);
  // R6: promiscuous mode accepts every completed address
  a_r6_promisc: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && $past(promisc)) |-> dec_accept);
endmodule

// File: tb/dest_addr_filter_tb.sv
module dest_addr_filter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_start = 1'b0, bit_vld = 1'b0, bit_in = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic dec_vld, dec_accept;

  int n_tests = 0, n_fail = 0, pulses = 0;
  logic [63:0] mask_m = '0;
  bit got_v, got_a, got_after, got_early;

  localparam logic [47:0] STA = 48'h02A4_1234_5670;
  localparam logic [47:0] M1  = 48'h0100_5E00_0001;
  localparam logic [47:0] M2  = 48'h3333_0000_00FB;
  localparam logic [47:0] M3  = 48'h0100_5E7F_FFFB;
  localparam logic [47:0] BCX = 48'h0ABC_DEF0_1235;

  // vector table: address, promiscuous, expected (0 reject, 1 accept, 2 by hash)
  localparam logic [47:0] V_ADDR [NV] = '{
    STA, STA ^ 48'h8000_0000_0000, STA ^ 48'h2, 48'hFFFF_FFFF_FFFF,
    M1, M2, M3, 48'h0000_0000_0001, STA ^ 48'h2, M3};
  localparam logic V_PRM [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1};
  localparam logic [1:0] V_EXP [NV] = '{1, 0, 0, 1, 2, 2, 2, 2, 1, 1};

  dest_addr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .bit_vld(bit_vld),
    .bit_in(bit_in), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .dec_vld(dec_vld), .dec_accept(dec_accept)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (dec_vld) pulses++;

  function automatic logic [5:0] hash_of(input logic [47:0] a);
    logic [31:0] c;
    c = '1;
    for (int i = 0; i < 48; i++) begin
      if (c[31] ^ a[i]) c = {c[30:0], 1'b0} ^ 32'h04C1_1DB7;
      else              c = {c[30:0], 1'b0};
    end
    return c[31:26];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [15:0] d);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr48(input logic [3:0] base, input logic [47:0] v);
    for (int w = 0; w < 3; w++) wr(base + 4'(w), v[w*16 +: 16]);
  endtask

  task automatic wr_mask(input logic [63:0] m);
    for (int w = 0; w < 4; w++) wr(4'd8 + 4'(w), m[w*16 +: 16]);
    mask_m = m;
  endtask

  // strobe, then nbits address bits; optional bit_vld on the strobe cycle
  task automatic send(input logic [47:0] a, input int nbits, input bit vld_on_strobe);
    frm_start = 1'b1; bit_vld = vld_on_strobe; bit_in = 1'b1;
    @(negedge clk);
    frm_start = 1'b0;
    got_early = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      bit_vld = 1'b1; bit_in = a[i];
      @(negedge clk);
      if (i != 47 && dec_vld) got_early = 1'b1;
    end
    got_v = dec_vld; got_a = dec_accept;
    bit_vld = 1'b0;
    @(negedge clk);
    got_after = dec_vld;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    chk(dec_vld == 1'b0 && dec_accept == 1'b0, "R1 outputs in reset", int'(dec_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dec_vld == 1'b0 && dec_accept == 1'b0, "R1 outputs after reset", int'(dec_vld), 0);

    // R8: bits with no frame opened yet
    p0 = pulses;
    bit_vld = 1'b1;
    for (int i = 0; i < 60; i++) begin bit_in = i[0]; @(negedge clk); end
    bit_vld = 1'b0;
    @(negedge clk);
    chk(pulses == p0, "R8 bits before any strobe", pulses - p0, 0);

    // R1/R4: default broadcast all ones accepted with zero mask
    send(48'hFFFF_FFFF_FFFF, 48, 1'b0);
    chk(got_v && got_a, "R1 R4 default broadcast", int'(got_a), 1);
    // R1/R5: zero mask rejects a multicast; R3: zero station rejects individual
    send(M1, 48, 1'b0);
    chk(got_v && !got_a, "R1 R5 reset mask rejects", int'(got_a), 0);
    send(STA, 48, 1'b0);
    chk(got_v && !got_a, "R1 R3 reset station", int'(got_a), 0);

    // R9: program registers
    wr48(4'd0, STA);
    wr_mask((64'd1 << hash_of(M1)) | (64'd1 << hash_of(M2)));

    // table walk
    for (int k = 0; k < NV; k++) begin
      logic expa;
      wr(4'd12, {15'd0, V_PRM[k]});
      send(V_ADDR[k], 48, 1'b0);
      expa = (V_EXP[k] == 2) ? mask_m[hash_of(V_ADDR[k])] : V_EXP[k][0];
      chk(!got_early && got_v && !got_after, "R2 verdict timing", int'(got_v), 1);
      chk(got_a == expa, V_PRM[k] ? "R6 promiscuous" :
          (V_ADDR[k][0] ? "R4 R5 group verdict" : "R3 individual verdict"),
          int'(got_a), int'(expa));
    end
    wr(4'd12, 16'd0);
    // R5: the wanted multicasts pass explicitly
    send(M2, 48, 1'b0);
    chk(got_a == 1'b1, "R5 wanted multicast", int'(got_a), 1);
    // R5: full mask passes any multicast
    wr_mask('1);
    send(M3, 48, 1'b0);
    chk(got_a == 1'b1, "R5 full mask", int'(got_a), 1);
    wr_mask('0);

    // R4: programmed broadcast pattern; old all-ones now rejected
    wr48(4'd4, BCX);
    send(BCX, 48, 1'b0);
    chk(got_v && got_a, "R4 programmed broadcast", int'(got_a), 1);
    send(48'hFFFF_FFFF_FFFF, 48, 1'b0);
    chk(got_v && !got_a, "R4 old pattern rejected", int'(got_a), 0);

    // R7: aborted frame yields one verdict, for the second address
    p0 = pulses;
    send(48'hFFFF_FFFF_FFFF, 20, 1'b0);
    send(STA, 48, 1'b0);
    chk(pulses - p0 == 1, "R7 abort single verdict", pulses - p0, 1);
    chk(got_a == 1'b1, "R7 restart address", int'(got_a), 1);
    // R7: bit on the strobe cycle is not taken
    send(STA, 48, 1'b1);
    chk(got_v && got_a && !got_early, "R7 strobe-cycle bit dropped", int'(got_a), 1);

    // R8: bits after the 48th are ignored
    frm_start = 1'b1; @(negedge clk); frm_start = 1'b0;
    p0 = pulses;
    bit_vld = 1'b1;
    for (int i = 0; i < 110; i++) begin bit_in = STA[i % 48]; @(negedge clk); end
    bit_vld = 1'b0;
    @(negedge clk);
    chk(pulses - p0 == 1, "R8 trailing bits ignored", pulses - p0, 1);
    chk(dec_accept == 1'b0, "R10 accept low when idle", int'(dec_accept), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule